// File: doc/BRIEF.md
# I2C Register-Write Target

This block is the bus-facing front end of a register-mapped peripheral that listens on a two-wire I2C bus. A fast system clock oversamples the clock and data lines through two-flop synchronizers, and the block finds START, repeated START and STOP conditions on the synchronized samples. The system clock must run at least eight times faster than SCL. After a START the block collects a device address byte. The upper five address bits are fixed by a parameter, and the two lower bits come from strap pins. The block then accepts a register address byte, checks it against a valid window, and takes up to two data bytes.

Each accepted data byte appears for one system clock on a write strobe, together with its register address and data. A host register file consumes these strobes directly. The target answers on the data line through an open-drain style output enable: a high enable pulls SDA low, which gives an ACK. Reads, clock stretching, 10-bit addressing and general call are not handled. A device address that matches but asks for a read gets a NACK.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, and whenever the bus is idle or after a STOP, `sda_oe` is low and `wr_en` is low.
- R2: Bytes are received MSB first, with one bit per SCL high period. A device address byte equal to {5'b01011, addr_strap, 1'b0} is ACKed. For straps 00, 01, 10 and 11 these are the codes 0x58, 0x5A, 0x5C and 0x5E. An ACK is `sda_oe` high during the ninth SCL high period of the byte.
- R3: A device address byte whose upper seven bits differ from {5'b01011, addr_strap} is not ACKed. No later byte is ACKed or written until the next START.
- R4: A matching device address with the direction bit high (codes 0x59, 0x5B, 0x5D, 0x5F) is NACKed. The rest of the transaction is ignored.
- R5: A register address byte inside [REG_FIRST, REG_LAST] (default 0x00 to 0x1F) is ACKed. Any other value is NACKed, and the data that follows is neither ACKed nor written.
- R6: The first data byte after a valid register address is ACKed. It is presented as `wr_addr` = register address and `wr_data` = the byte.
- R7: The second data byte is ACKed and written to register address plus one, modulo 256. A third or later byte is NACKed and not written.
- R8: A repeated START at any point, including the middle of a byte, drops the partial byte and restarts device address reception.
- R9: After a STOP, bytes clocked without a new START are neither ACKed nor written.
- R10: `sda_oe` changes only while the synchronized SCL is low. The ACK is released after the falling edge of the ninth clock.
- R11: Each accepted data byte raises `wr_en` for exactly one system clock, while the ACK for that byte is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| addr_strap | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | Pull SDA low when high (ACK) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The bench sends the address at the upper edge of the register window, with two data bytes. A design that applied the range check to the second byte, or failed to add one to the address, would drop or misplace that write. It also cuts a register address off after four bits with a repeated START. A design that kept its bit counter across the START would misread the next device address and NACK a valid transaction. A byte clocked after a STOP without a new START tests that STOP really returns the block to idle; a block that stayed in its receive state would ACK that byte. A third data byte, read-direction codes for every strap setting, and random address and data traffic complete the checks. Those cases catch an off-by-one burst limit, a block that answers reads, and a block that ignores the strap pins.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [4:0] DEV_PREFIX = 5'b01011,
  parameter int REG_FIRST = 0,
  parameter int REG_LAST = 31,
  parameter int MAX_BURST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam int CW = $clog2(MAX_BURST + 1);
  localparam logic [7:0] RF = 8'(REG_FIRST);
  localparam logic [7:0] RSPAN = 8'(REG_LAST - REG_FIRST);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st, nxt;
  logic [7:0] shreg, base;
  logic [2:0] bitcnt;
  logic full, ack_ph;
  logic [CW-1:0] nbytes;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c = scl_s & scl_q & ~sda_q & sda_s;

  wire dev_hit = shreg[7:1] == {DEV_PREFIX, addr_strap};
  wire reg_ok = (shreg - RF) <= RSPAN;
  wire burst_ok = nbytes < CW'(MAX_BURST);
  wire receiving = (st == S_DEV) || (st == S_REG) || (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nxt <= S_IDLE;
      shreg <= '0;
      base <= '0;
      bitcnt <= '0;
      full <= 1'b0;
      ack_ph <= 1'b0;
      nbytes <= '0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c || stop_c) begin
        st <= start_c ? S_DEV : S_IDLE;
        bitcnt <= '0;
        full <= 1'b0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && !full && !ack_ph) begin
          shreg <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) full <= 1'b1;
        end else if (scl_fall && full) begin
          full <= 1'b0;
          ack_ph <= 1'b1;
          nxt <= S_SKIP;
          case (st)
            S_DEV: if (dev_hit && !shreg[0]) begin
              sda_oe <= 1'b1;
              nxt <= S_REG;
            end
            S_REG: if (reg_ok) begin
              sda_oe <= 1'b1;
              base <= shreg;
              nbytes <= '0;
              nxt <= S_DATA;
            end
            S_DATA: if (burst_ok) begin
              sda_oe <= 1'b1;
              wr_en <= 1'b1;
              wr_addr <= base + 8'(nbytes);
              wr_data <= shreg;
              nbytes <= nbytes + 1'b1;
              nxt <= S_DATA;
            end
            default: nxt <= S_SKIP;
          endcase
        end else if (scl_fall && ack_ph) begin
          ack_ph <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
          st <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_c,
  input logic       stop_c,
  input logic       ack_ph,
  input logic [2:0] st,
  input logic       sda_oe,
  input logic       wr_en
);
  // State codes: 0 = idle, 1 = device address reception
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> (!sda_oe && !wr_en));

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r11_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);

  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == 3'd1 && !sda_oe && !ack_ph));

  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == 3'd0 && !sda_oe));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
  .ack_ph(ack_ph), .st(st), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int CLK_P = 10;
  localparam int RMIN = 0;
  localparam int RMAX = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int wcnt = 0;
  logic [7:0] cap_a [8];
  logic [7:0] cap_d [8];

  always #(CLK_P/2) clk = ~clk;

  i2c_reg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en) begin
    cap_a[wcnt % 8] = wr_addr;
    cap_d[wcnt % 8] = wr_data;
    wcnt = wcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit dev_ok(input logic [7:0] d, input logic [1:0] s);
    return d[7:1] == {5'b01011, s} && !d[0];
  endfunction

  function automatic bit reg_valid(input logic [7:0] r);
    return int'(r) >= RMIN && int'(r) <= RMAX;
  endfunction

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = ~sda_line;
    q(); scl_m = 1'b0; q();
    chk(sda_oe == 1'b0, "R10 ack released", int'(sda_oe), 0);
  endtask

  task automatic run_txn(input logic [7:0] dev, input logic [7:0] ra, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    bit ack, e;
    int w0, exp_w;
    logic [7:0] dd;
    string tag;
    w0 = wcnt;
    exp_w = 0;
    do_start();
    send_byte(dev, ack);
    e = dev_ok(dev, strap);
    if (dev[7:1] == {5'b01011, strap}) tag = dev[0] ? "R4 read nack" : "R2 dev ack";
    else tag = "R3 dev mismatch";
    chk(ack == e, tag, int'(ack), int'(e));
    send_byte(ra, ack);
    e = dev_ok(dev, strap) && reg_valid(ra);
    chk(ack == e, "R5 reg ack", int'(ack), int'(e));
    for (int k = 0; k < n; k++) begin
      dd = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(dd, ack);
      e = dev_ok(dev, strap) && reg_valid(ra) && k < 2;
      chk(ack == e, k < 2 ? "R6 data ack" : "R7 third byte nack", int'(ack), int'(e));
      if (e) begin
        chk(cap_a[(w0 + exp_w) % 8] == ra + 8'(k), k == 0 ? "R6 wr_addr" : "R7 wr_addr+1",
            int'(cap_a[(w0 + exp_w) % 8]), int'(ra + 8'(k)));
        chk(cap_d[(w0 + exp_w) % 8] == dd, "R6 wr_data", int'(cap_d[(w0 + exp_w) % 8]), int'(dd));
        exp_w++;
      end
    end
    chk(wcnt - w0 == exp_w, "R11 strobe count", wcnt - w0, exp_w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    int w0;
    void'($urandom(32'h1c2b));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);

    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      q();
      run_txn(8'h58 + 8'(2*s), 8'h05, 1, 8'hA0 + 8'(s), 8'h00, 8'h00);
      do_stop();
      run_txn(8'h59 + 8'(2*s), 8'h05, 1, 8'h11, 8'h00, 8'h00);
      do_stop();
      chk(sda_oe == 1'b0, "R1 idle after stop", int'(sda_oe), 0);
    end

    strap = 2'b10;
    q();
    run_txn(8'h58, 8'h03, 1, 8'h77, 8'h00, 8'h00);
    do_stop();
    run_txn(8'h5C, 8'(RMAX), 3, 8'h12, 8'h34, 8'h56);
    do_stop();
    run_txn(8'h5C, 8'(RMAX + 1), 2, 8'h9A, 8'hBC, 8'h00);
    do_stop();

    do_start();
    send_byte(8'h5C, ack);
    chk(ack, "R8 dev ack before abort", int'(ack), 1);
    send_bits(8'h0F, 4);
    run_txn(8'h5C, 8'h02, 2, 8'hC3, 8'h3C, 8'h00);
    do_stop();

    w0 = wcnt;
    send_byte(8'h5C, ack);
    chk(!ack, "R9 no ack after stop", int'(ack), 0);
    send_byte(8'h04, ack);
    chk(!ack, "R9 no ack after stop", int'(ack), 0);
    chk(wcnt == w0, "R9 no write after stop", wcnt - w0, 0);
    do_start();
    do_stop();

    for (int t = 0; t < 60; t++) begin
      logic [7:0] dev, ra;
      if ($urandom % 3 == 0) begin
        do_stop();
        strap = 2'($urandom);
        q();
      end
      case ($urandom % 5)
        0: dev = 8'($urandom);
        1: dev = {5'b01011, strap, 1'b1};
        default: dev = {5'b01011, strap, 1'b0};
      endcase
      ra = 8'($urandom % 48);
      run_txn(dev, ra, int'($urandom % 4), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    do_stop();
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R1 final idle", int'({sda_oe, wr_en}), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule